// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block owns the 64-bit base-address register that places the memory-mapped PCIe configuration window in the physical address map. Software programs the register through a dword-wide configuration write port. The port carries per-byte enables, so partial writes are possible. From the register's enable bit, its 2-bit length code and its address bits, the block keeps a decoded window: an enable, a base address and a size.

For each cycle, the block compares a 64-bit physical lookup address against the decoded window. It reports a hit flag and the offset of the address inside the window. The offset is the value that downstream logic would split into bus, device, function and register fields; that split is not part of this block.

The register layout is as follows:
- Bit 0 is the window enable.
- Bits 2:1 hold the length code.
- Bits 39:26 carry the candidate base address.

The length code sets how many of the low base bits take part. Code 3 is reserved. When a write leaves that code in the register, the decoded window does not change and a guest-error pulse is raised.

Top module: `pcie_cfg_window`

## Requirements
- R1: After reset the decoded window is enabled, with base 0xB000_0000 and size 256 MiB (0x1000_0000), and `lenReservedErr` is low.
- R2: The length code in register bits 2:1 selects the window size: 0 gives 256 MiB, 1 gives 128 MiB and 2 gives 64 MiB.
- R3: The window base keeps only register bits 39:28 for 256 MiB, bits 39:27 for 128 MiB and bits 39:26 for 64 MiB. All other register bits read as zero in `winBase`, including bits 63:40.
- R4: A write that leaves length code 3 in the register leaves `winEnable`, `winBase` and `winSize` unchanged. It raises `lenReservedErr` for exactly the one cycle after the write edge.
- R5: `winEnable` follows register bit 0. While it is low, `hit` stays low.
- R6: The register sits at byte offset REG_OFFSET (default 0x60); its low dword is at that offset and its high dword at REG_OFFSET+4. A write to any other dword changes nothing. A write with all byte enables low also changes nothing. Otherwise only the bytes whose enable is set change.
- R7: A write to the high dword sets register bits 63:32, so bits 39:32 move the window base above 4 GiB.
- R8: `hit` is high exactly when the window is enabled and winBase ≤ lookupAddr < winBase + winSize. `hitOffset` is lookupAddr − winBase on a hit and zero otherwise.
- R9: A write that changes the window takes effect on the clock edge that accepts it. In the cycle that presents the write, `hit` still uses the previous window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrAddr | input | CFG_AW | Byte address of the write; bits 1:0 are ignored |
| cfgWrData | input | 32 | Write data, byte lane b at bits 8b+7:8b |
| cfgWrBe | input | 4 | Byte enables, one per lane |
| lookupAddr | input | 64 | Physical address to decode |
| winEnable | output | 1 | Decoded window is live |
| winBase | output | 64 | Decoded window base |
| winSize | output | 64 | Decoded window size in bytes |
| hit | output | 1 | lookupAddr lies inside the live window |
| hitOffset | output | 64 | Offset of lookupAddr inside the window, zero on a miss |
| lenReservedErr | output | 1 | One-cycle pulse after a write leaving the reserved length code |

## Verification
Two things can fall in the same cycle: a register write that moves the window, and a lookup against that window. To provoke this, the bench holds a lookup address that lies just outside the old window but inside the new one. It then presents the write. The bench samples `hit` while the write is still being driven and expects a miss, because the old window still applies. It samples again after the accepting edge and expects a hit, with the offset measured from the new base. The reserved-length pulse is judged in the same way: in the one cycle where the pulse is high, the window outputs must read as they did before the write.

// File: rtl/pcie_cfg_window_pkg.sv
package pcie_cfg_window_pkg;

  localparam int REG_W = 64;

  typedef enum logic [1:0] {
    LEN_256M = 2'b00,
    LEN_128M = 2'b01,
    LEN_64M  = 2'b10,
    LEN_RSVD = 2'b11
  } winLen_e;

  // address decode of the write port, driven by control
  typedef struct packed {
    logic lo;
    logic hi;
  } wrSel_t;

  // commit strobes from control to the datapath
  typedef struct packed {
    logic load;   // register bytes take the write
    logic apply;  // decoded window takes the merged register
  } commit_t;

endpackage

// File: rtl/pcie_cfg_window_ctl.sv
module pcie_cfg_window_ctl
  import pcie_cfg_window_pkg::*;
#(
  parameter int CFG_AW = 8,
  parameter int REG_OFFSET = 'h60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgWrAddr,
  input  logic [3:0]        cfgWrBe,
  input  winLen_e           mergedLen,
  output wrSel_t            wrSel,
  output commit_t           commit,
  output logic              lenReservedErr
);
  localparam int DW_AW = CFG_AW - 2;
  localparam logic [DW_AW-1:0] LO_DW = DW_AW'(REG_OFFSET / 4);
  localparam logic [DW_AW-1:0] HI_DW = DW_AW'(REG_OFFSET / 4 + 1);

  logic [DW_AW-1:0] wrDw;
  logic touch;
  logic errQ;

  assign wrDw = cfgWrAddr[CFG_AW-1:2];

  always_comb begin
    wrSel.lo = cfgWrEn && (wrDw == LO_DW);
    wrSel.hi = cfgWrEn && (wrDw == HI_DW);
  end

  assign touch = (wrSel.lo || wrSel.hi) && (cfgWrBe != 4'b0000);

  always_comb begin
    commit.load  = touch;
    commit.apply = touch && (mergedLen != LEN_RSVD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= touch && (mergedLen == LEN_RSVD);
  end

  assign lenReservedErr = errQ;

endmodule

// File: rtl/pcie_cfg_window_dp.sv
module pcie_cfg_window_dp
  import pcie_cfg_window_pkg::*;
#(
  parameter int PHYS_W = 40,
  parameter int TOP_SHIFT = 28,
  parameter logic [REG_W-1:0] RST_REG = 64'h0000_0000_B000_0001
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrSel_t           wrSel,
  input  commit_t          commit,
  input  logic [31:0]      wrData,
  input  logic [3:0]       wrBe,
  input  logic [REG_W-1:0] lookupAddr,
  output winLen_e          mergedLen,
  output logic             winEnable,
  output logic [REG_W-1:0] winBase,
  output logic [REG_W-1:0] winSize,
  output logic             hit,
  output logic [REG_W-1:0] hitOffset
);
  localparam logic [REG_W-1:0] PHYS_MASK = (REG_W'(1) << PHYS_W) - REG_W'(1);
  localparam int RST_LEN = int'(RST_REG[2:1]);
  localparam logic [REG_W-1:0] RST_SIZE = REG_W'(1) << (TOP_SHIFT - RST_LEN);
  localparam logic [REG_W-1:0] RST_BASE = RST_REG & ~(RST_SIZE - REG_W'(1)) & PHYS_MASK;

  logic [REG_W-1:0] regQ, regNext;
  logic             enQ;
  logic [REG_W-1:0] baseQ, sizeQ;
  logic [REG_W-1:0] sizeDec, baseDec;
  logic [REG_W-1:0] delta;

  // byte-lane merge into both dwords
  always_comb begin
    regNext = regQ;
    for (int b = 0; b < 4; b++) begin
      if (wrBe[b] && wrSel.lo) regNext[8*b +: 8] = wrData[8*b +: 8];
      if (wrBe[b] && wrSel.hi) regNext[32 + 8*b +: 8] = wrData[8*b +: 8];
    end
  end

  assign mergedLen = winLen_e'(regNext[2:1]);
  assign sizeDec   = REG_W'(1) << (TOP_SHIFT - int'(regNext[2:1]));
  assign baseDec   = regNext & ~(sizeDec - REG_W'(1)) & PHYS_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ  <= RST_REG;
      enQ   <= RST_REG[0];
      baseQ <= RST_BASE;
      sizeQ <= RST_SIZE;
    end else begin
      if (commit.load) regQ <= regNext;
      if (commit.apply) begin
        enQ   <= regNext[0];
        baseQ <= baseDec;
        sizeQ <= sizeDec;
      end
    end
  end

  assign delta     = lookupAddr - baseQ;
  assign hit       = enQ && (lookupAddr >= baseQ) && (delta < sizeQ);
  assign hitOffset = hit ? delta : '0;
  assign winEnable = enQ;
  assign winBase   = baseQ;
  assign winSize   = sizeQ;

endmodule

// File: rtl/pcie_cfg_window.sv
module pcie_cfg_window
  import pcie_cfg_window_pkg::*;
#(
  parameter int CFG_AW = 8,
  parameter int REG_OFFSET = 'h60,
  parameter int PHYS_W = 40,
  parameter int TOP_SHIFT = 28,
  parameter logic [63:0] RST_REG = 64'h0000_0000_B000_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgWrAddr,
  input  logic [31:0]       cfgWrData,
  input  logic [3:0]        cfgWrBe,
  input  logic [63:0]       lookupAddr,
  output logic              winEnable,
  output logic [63:0]       winBase,
  output logic [63:0]       winSize,
  output logic              hit,
  output logic [63:0]       hitOffset,
  output logic              lenReservedErr
);
  wrSel_t  wrSel;
  commit_t commit;
  winLen_e mergedLen;

  pcie_cfg_window_ctl #(.CFG_AW(CFG_AW), .REG_OFFSET(REG_OFFSET)) ctl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr),
    .cfgWrBe(cfgWrBe), .mergedLen(mergedLen), .wrSel(wrSel),
    .commit(commit), .lenReservedErr(lenReservedErr)
  );

  pcie_cfg_window_dp #(.PHYS_W(PHYS_W), .TOP_SHIFT(TOP_SHIFT), .RST_REG(RST_REG)) dp (
    .clk(clk), .rstN(rstN), .wrSel(wrSel), .commit(commit),
    .wrData(cfgWrData), .wrBe(cfgWrBe), .lookupAddr(lookupAddr),
    .mergedLen(mergedLen), .winEnable(winEnable), .winBase(winBase),
    .winSize(winSize), .hit(hit), .hitOffset(hitOffset)
  );

endmodule

// File: rtl/pcie_cfg_window_chk.sv
module pcie_cfg_window_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrEn,
  input logic [63:0] lookupAddr,
  input logic        winEnable,
  input logic [63:0] winBase,
  input logic [63:0] winSize,
  input logic        hit,
  input logic [63:0] hitOffset,
  input logic        lenReservedErr
);
  // R2: size is always one power of two
  assert_size_pow2_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(winSize) == 1);

  // R3: base aligned to the decoded size
  assert_base_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    (winBase & (winSize - 64'd1)) == 64'd0);

  // R4: pulse cycle shows the window from before the write
  assert_rsvd_keeps_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    lenReservedErr |-> ($stable(winBase) && $stable(winSize) && $stable(winEnable)));

  // R5: no hit on a disabled window
  assert_disabled_no_hit_R5: assert property (@(posedge clk) disable iff (!rstN)
    !winEnable |-> !hit);

  // R6: no write, no change
  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> ($stable(winBase) && $stable(winSize) && $stable(winEnable)));

  // R8: miss gives zero offset; hit lies at or above the base
  assert_miss_zero_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> hitOffset == 64'd0);
  assert_hit_above_base_R8: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (lookupAddr >= winBase && hitOffset < winSize));

endmodule

bind pcie_cfg_window pcie_cfg_window_chk chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .lookupAddr(lookupAddr),
  .winEnable(winEnable), .winBase(winBase), .winSize(winSize),
  .hit(hit), .hitOffset(hitOffset), .lenReservedErr(lenReservedErr)
);

// File: tb/pcie_cfg_window_test.sv
module pcie_cfg_window_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] LO = 8'h60;
  localparam logic [7:0] HI = 8'h64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgWrAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [3:0]  cfgWrBe = '0;
  logic [63:0] lookupAddr = '0;
  logic        winEnable, hit, lenReservedErr;
  logic [63:0] winBase, winSize, hitOffset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcie_cfg_window uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr),
    .cfgWrData(cfgWrData), .cfgWrBe(cfgWrBe), .lookupAddr(lookupAddr),
    .winEnable(winEnable), .winBase(winBase), .winSize(winSize),
    .hit(hit), .hitOffset(hitOffset), .lenReservedErr(lenReservedErr)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrAddr = a; cfgWrData = d; cfgWrBe = be;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgWrBe = '0;
  endtask

  task automatic checkWin(input string tag, input logic en, input logic [63:0] base,
                          input logic [63:0] size);
    check({tag, " enable"}, 64'(winEnable), 64'(en));
    check({tag, " base"}, winBase, base);
    check({tag, " size"}, winSize, size);
  endtask

  task automatic checkHit(input string tag, input logic [63:0] a, input logic h,
                          input logic [63:0] off);
    lookupAddr = a;
    #1;
    check({tag, " hit"}, 64'(hit), 64'(h));
    check({tag, " offset"}, hitOffset, off);
  endtask

  task automatic testReset;
    checkWin("R1 reset", 1'b1, 64'hB000_0000, 64'h1000_0000);
    check("R1 reset err", 64'(lenReservedErr), 64'd0);
    checkHit("R8 inside", 64'hB000_0123, 1'b1, 64'h123);
    checkHit("R8 below", 64'hAFFF_FFFF, 1'b0, 64'd0);
    checkHit("R8 upper bound", 64'hC000_0000, 1'b0, 64'd0);
  endtask

  task automatic testLengths;
    cfgWrite(LO, 32'hB800_0003, 4'hF);
    checkWin("R2 128M", 1'b1, 64'hB800_0000, 64'h0800_0000);
    checkHit("R8 last byte", 64'hBFFF_FFFF, 1'b1, 64'h07FF_FFFF);
    checkHit("R8 below 128M", 64'hB7FF_FFFF, 1'b0, 64'd0);
    cfgWrite(LO, 32'hBC00_0005, 4'hF);
    checkWin("R2 64M", 1'b1, 64'hBC00_0000, 64'h0400_0000);
    cfgWrite(LO, 32'hBC00_0001, 4'hF);
    checkWin("R3 256M drops 27:26", 1'b1, 64'hB000_0000, 64'h1000_0000);
    cfgWrite(LO, 32'hB800_0005, 4'hF);
    checkWin("R3 64M keeps 27", 1'b1, 64'hB800_0000, 64'h0400_0000);
    cfgWrite(LO, 32'hB400_0003, 4'hF);
    checkWin("R3 128M drops 26", 1'b1, 64'hB000_0000, 64'h0800_0000);
  endtask

  task automatic testHighDword;
    cfgWrite(HI, 32'h0000_00A5, 4'b0001);
    checkWin("R7 high base", 1'b1, 64'hA5_B000_0000, 64'h0800_0000);
    checkHit("R7 hit high", 64'hA5_B000_0010, 1'b1, 64'h10);
    checkHit("R7 low alias miss", 64'h00_B000_0010, 1'b0, 64'd0);
    cfgWrite(HI, 32'hFFFF_FF00, 4'b1110);
    checkWin("R3 bits above 39", 1'b1, 64'hA5_B000_0000, 64'h0800_0000);
    cfgWrite(HI, 32'h0, 4'hF);
    checkWin("R7 clear high", 1'b1, 64'hB000_0000, 64'h0800_0000);
  endtask

  task automatic testReserved;
    cfgWrite(LO, 32'h1234_5007, 4'hF);
    check("R4 err pulse", 64'(lenReservedErr), 64'd1);
    checkWin("R4 window kept", 1'b1, 64'hB000_0000, 64'h0800_0000);
    @(negedge clk);
    check("R4 pulse one cycle", 64'(lenReservedErr), 64'd0);
    cfgWrite(HI, 32'h0000_0011, 4'hF);
    check("R4 err on high write", 64'(lenReservedErr), 64'd1);
    checkWin("R4 high write kept", 1'b1, 64'hB000_0000, 64'h0800_0000);
    cfgWrite(LO, 32'hC000_0001, 4'hF);
    check("R4 err clears", 64'(lenReservedErr), 64'd0);
    checkWin("R4 recover", 1'b1, 64'h11_C000_0000, 64'h1000_0000);
    cfgWrite(HI, 32'h0, 4'hF);
    checkWin("R7 back low", 1'b1, 64'hC000_0000, 64'h1000_0000);
  endtask

  task automatic testBytesEnable;
    cfgWrite(LO, 32'hD0FF_FF00, 4'b1000);
    checkWin("R6 top byte only", 1'b1, 64'hD000_0000, 64'h1000_0000);
    cfgWrite(LO, 32'hFFFF_FF00, 4'b0001);
    checkWin("R5 disable", 1'b0, 64'hD000_0000, 64'h1000_0000);
    checkHit("R5 no hit", 64'hD000_0000, 1'b0, 64'd0);
    cfgWrite(LO, 32'hFFFF_FFFF, 4'b0000);
    checkWin("R6 zero enables", 1'b0, 64'hD000_0000, 64'h1000_0000);
    cfgWrite(8'h68, 32'h0000_0001, 4'hF);
    checkWin("R6 other offset", 1'b0, 64'hD000_0000, 64'h1000_0000);
    cfgWrite(LO, 32'h0000_0005, 4'b0001);
    checkWin("R5 re-enable", 1'b1, 64'hD000_0000, 64'h0400_0000);
    checkHit("R8 64M hit", 64'hD3FF_FFF0, 1'b1, 64'h03FF_FFF0);
  endtask

  task automatic testWriteDuringLookup;
    cfgWrite(LO, 32'hB000_0001, 4'hF);
    lookupAddr = 64'hC000_0010;
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrAddr = LO; cfgWrData = 32'hC000_0001; cfgWrBe = 4'hF;
    #1;
    check("R9 old window hit", 64'(hit), 64'd0);
    @(negedge clk);
    cfgWrEn = 1'b0; cfgWrBe = '0;
    #1;
    check("R9 new window hit", 64'(hit), 64'd1);
    check("R9 new offset", hitOffset, 64'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLengths();
    testHighDword();
    testReserved();
    testBytesEnable();
    testWriteDuringLookup();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule